// File: doc/BRIEF.md
# SPI Target Transfer Engine

This block is the serial core of an SPI target (slave) that runs on a fast system clock. The external serial clock, the active-low select and the serial data input are brought into the system clock domain through two-flop synchronizers. All edge detection happens there. The system clock must therefore run at least eight times faster than the serial clock.

Before a transfer, the host logic preloads a transmit word with a one-cycle load strobe. The engine shifts that word out on the serial output and assembles the received word at the same time. Software-visible registers and flags live elsewhere. The engine only emits a one-cycle completion strobe, or a one-cycle abort strobe when the select is released early.

Clock polarity, clock phase, bit order and a 4-bit length code are static inputs. They must not change while a transfer is in progress.

Top module: `spi_tgt_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `abort_o` and `miso_oe_o` are 0, and `rx_word_o` is 0.
- R2: The length code selects the word size. Code 0 means 16 bits, codes 8 to 15 mean that many bits, and codes 1 to 7 are treated as 8 bits. The received word is right-aligned and its unused upper bits are 0.
- R3: With `cfg_lsb_first`=0 the word is sent and received most significant bit first. With `cfg_lsb_first`=1 it is sent and received bit 0 first.
- R4: The leading SCK edge is the transition away from the idle level given by `cfg_cpol`. With `cfg_cpha`=0, data is sampled on leading edges and changed on trailing edges. With `cfg_cpha`=1, data is changed on leading edges and sampled on trailing edges.
- R5: With `cfg_cpha`=0, a transfer starts when the select falls, and the first transmit bit is already on `miso_o` before the first SCK edge.
- R6: With `cfg_cpha`=1, a transfer starts on the first leading SCK edge while the target is selected, and the first bit is presented from that edge.
- R7: After the last sampling edge of a full-length transfer, `done_o` pulses for exactly one cycle. At the same moment `rx_word_o` takes the received word, no later than three system clocks after the edge at the pins.
- R8: A select rise before the last bit pulses `abort_o` for one cycle, produces no `done_o`, and leaves `rx_word_o` unchanged. It also discards the transmit word: a following transfer with no new load sends all zeros.
- R9: `miso_oe_o` equals the inverse of the select input delayed by the two synchronizer stages.
- R10: A `tx_load` pulse while a transfer is in progress has no effect on the bits sent on `miso_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_len_code | input | 4 | Word length code |
| tx_load | input | 1 | Load strobe for the transmit word |
| tx_word | input | 16 | Transmit word |
| sck_i | input | 1 | Serial clock pin |
| ssel_n_i | input | 1 | Active-low select pin |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| rx_word_o | output | 16 | Last completed received word |
| done_o | output | 1 | Completion strobe |
| abort_o | output | 1 | Abort strobe |
| busy_o | output | 1 | Transfer in progress |

## Verification
A wrong bit counter or shift direction shows up as a wrong `miso_o` bit at the very next sampling point of the external master, well before the transfer ends. The same fault also gives a mismatched `rx_word_o` or a missing or doubled `done_o` within three system clocks of the last edge. A busy flag that is not cleared on deselect shows up as a missing `abort_o`, or as stale transmit bits in the following transfer. An enable that is out of step is caught on every system clock against the delayed select.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic lsb_first;
    } spi_tgt_mode_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    // stages 0..STAGES-1 synchronize, stage STAGES holds the previous level
    typedef logic [STAGES:0][N-1:0] pipe_t;
    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw_i;
        for (int s = 1; s <= STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign lvl_o[g]  = pipe_q[STAGES-1][g];
        assign rise_o[g] = pipe_q[STAGES-1][g] & ~pipe_q[STAGES][g];
        assign fall_o[g] = ~pipe_q[STAGES-1][g] & pipe_q[STAGES][g];
    end

endmodule

// File: rtl/spi_tgt_phase.sv
module spi_tgt_phase
    import spi_tgt_pkg::*;
(
    input  spi_tgt_mode_t mode_i,
    input  logic          sck_rise_i,
    input  logic          sck_fall_i,
    output logic          sample_evt_o,
    output logic          shift_evt_o
);
    logic lead_evt, trail_evt;

    always_comb begin
        lead_evt     = mode_i.cpol ? sck_fall_i : sck_rise_i;
        trail_evt    = mode_i.cpol ? sck_rise_i : sck_fall_i;
        sample_evt_o = mode_i.cpha ? trail_evt : lead_evt;
        shift_evt_o  = mode_i.cpha ? lead_evt  : trail_evt;
    end

endmodule

// File: rtl/spi_tgt_core.sv
module spi_tgt_core
    import spi_tgt_pkg::*;
#(
    parameter int W = 16,
    parameter int MIN_W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spi_tgt_mode_t    mode_i,
    input  logic [IDX_W-1:0] len_code_i,
    input  logic             tx_load_i,
    input  logic [W-1:0]     tx_word_i,
    input  logic             mosi_i,
    input  logic             ssel_act_i,
    input  logic             ssel_fall_i,
    input  logic             ssel_rise_i,
    input  logic             sample_evt_i,
    input  logic             shift_evt_i,
    output logic             miso_o,
    output logic [W-1:0]     rx_word_o,
    output logic             done_o,
    output logic             abort_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             busy;
        logic [W-1:0]     tx;
        logic [W-1:0]     rx;
        logic [W-1:0]     rx_out;
        logic [IDX_W-1:0] cnt;
        logic             done;
        logic             abort;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic [W-1:0]     rx_next, tx_next;
    logic             start;

    always_comb begin
        if (len_code_i == '0)                     last_idx = IDX_W'(W - 1);
        else if (len_code_i < IDX_W'(MIN_W))      last_idx = IDX_W'(MIN_W - 1);
        else                                      last_idx = len_code_i - 1'b1;
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.abort = 1'b0;

        rx_next = st_q.rx;
        if (mode_i.lsb_first) rx_next[st_q.cnt] = mosi_i;
        else                  rx_next = {st_q.rx[W-2:0], mosi_i};
        tx_next = mode_i.lsb_first ? (st_q.tx >> 1) : (st_q.tx << 1);

        start = mode_i.cpha ? (shift_evt_i && ssel_act_i) : ssel_fall_i;

        if (!st_q.busy) begin
            if (tx_load_i) st_d.tx = tx_word_i;
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.rx   = '0;
            end
        end else if (ssel_rise_i) begin
            st_d.busy  = 1'b0;
            st_d.abort = 1'b1;
            st_d.tx    = '0;
            st_d.rx    = '0;
        end else begin
            if (sample_evt_i) begin
                st_d.rx = rx_next;
                if (st_q.cnt == last_idx) begin
                    st_d.busy   = 1'b0;
                    st_d.done   = 1'b1;
                    st_d.rx_out = rx_next;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (shift_evt_i) st_d.tx = tx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso_o    = mode_i.lsb_first ? st_q.tx[0] : st_q.tx[last_idx];
    assign rx_word_o = st_q.rx_out;
    assign done_o    = st_q.done;
    assign abort_o   = st_q.abort;
    assign busy_o    = st_q.busy;

    // R7: a completion only ends a transfer that was running
    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (!st_q.busy && $past(st_q.busy)));

    // R8: an abort only ends a transfer that was running
    a_r8_abort_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.abort |-> (!st_q.busy && $past(st_q.busy)));

    // R8: never both strobes together
    a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.done && st_q.abort));

    // R2: the bit counter stays inside the selected length
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt <= last_idx));

    // R4: sampling and changing never fall on the same cycle
    a_r4_edges_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_evt_i && shift_evt_i));

    // R10: a load during a transfer leaves the shift register alone
    a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && tx_load_i && !shift_evt_i && !ssel_rise_i) |=> $stable(st_q.tx));

endmodule

// File: rtl/spi_tgt_engine.sv
module spi_tgt_engine
    import spi_tgt_pkg::*;
#(
    parameter int W = 16,
    parameter int MIN_W = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb_first,
    input  logic [IDX_W-1:0] cfg_len_code,
    input  logic             tx_load,
    input  logic [W-1:0]     tx_word,
    input  logic             sck_i,
    input  logic             ssel_n_i,
    input  logic             mosi_i,
    output logic             miso_o,
    output logic             miso_oe_o,
    output logic [W-1:0]     rx_word_o,
    output logic             done_o,
    output logic             abort_o,
    output logic             busy_o
);
    // bit 0: SCK, bit 1: select (idle high), bit 2: data in
    logic [2:0] lvl, rise, fall;
    logic sample_evt, shift_evt;
    spi_tgt_mode_t mode;

    assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha, lsb_first: cfg_lsb_first};

    spi_tgt_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({mosi_i, ssel_n_i, sck_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_tgt_phase u_phase (
        .mode_i       (mode),
        .sck_rise_i   (rise[0]),
        .sck_fall_i   (fall[0]),
        .sample_evt_o (sample_evt),
        .shift_evt_o  (shift_evt)
    );

    spi_tgt_core #(.W(W), .MIN_W(MIN_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .len_code_i   (cfg_len_code),
        .tx_load_i    (tx_load),
        .tx_word_i    (tx_word),
        .mosi_i       (lvl[2]),
        .ssel_act_i   (~lvl[1]),
        .ssel_fall_i  (fall[1]),
        .ssel_rise_i  (rise[1]),
        .sample_evt_i (sample_evt),
        .shift_evt_i  (shift_evt),
        .miso_o       (miso_o),
        .rx_word_o    (rx_word_o),
        .done_o       (done_o),
        .abort_o      (abort_o),
        .busy_o       (busy_o)
    );

    assign miso_oe_o = ~lvl[1];

    // R8: once deselected, no transfer remains running
    a_r8_deselect_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |=> !busy_o);

endmodule

// File: tb/spi_tgt_engine_tb_top.sv
`timescale 1ns/1ps
module spi_tgt_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_len_code = 4'd8;
    logic        tx_load = 1'b0;
    logic [15:0] tx_word = '0;
    logic        sck = 1'b0, ssel_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe, done, abort_s, busy;
    logic [15:0] rx_word;

    int checks = 0, failures = 0;
    int done_cnt = 0, abort_cnt = 0;
    logic [1:0] ssel_hist = 2'b11;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_tgt_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_len_code(cfg_len_code),
        .tx_load(tx_load), .tx_word(tx_word), .sck_i(sck), .ssel_n_i(ssel_n),
        .mosi_i(mosi), .miso_o(miso), .miso_oe_o(miso_oe), .rx_word_o(rx_word),
        .done_o(done), .abort_o(abort_s), .busy_o(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: strobe counts and the delayed select
    always @(posedge clk) begin
        if (!rst_n) ssel_hist <= 2'b11;
        else        ssel_hist <= {ssel_hist[0], ssel_n};
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done)    done_cnt++;
            if (abort_s) abort_cnt++;
            chk("R9 output enable", {31'd0, miso_oe}, {31'd0, ~ssel_hist[1]});
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] w);
        tx_word = w;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // external master; stop_at < 0 means a full transfer
    task automatic xfer(input string req, input bit cpol, input bit cpha, input bit lsb,
                        input logic [3:0] code, input logic [15:0] tx, input logic [15:0] mo,
                        input int stop_at, input bit do_load, input bit mid_load);
        int n;
        int d0, a0;
        logic [15:0] prev_rx, mask;
        n = (code == 4'd0) ? 16 : ((code < 4'd8) ? 8 : int'(code));
        mask = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_lsb_first = lsb; cfg_len_code = code;
        sck = cpol;
        wait_clk(8);
        if (do_load) load(tx);
        wait_clk(8);
        ssel_n = 1'b0;
        wait_clk(8);
        d0 = done_cnt; a0 = abort_cnt; prev_rx = rx_word;
        for (int i = 0; i < n; i++) begin
            logic eb, mb;
            if (i == stop_at) break;
            eb = lsb ? tx[i] : tx[n-1-i];
            mb = lsb ? mo[i] : mo[n-1-i];
            if (!cpha) begin
                mosi = mb;
                wait_clk(8);
                chk({req, " miso bit"}, {31'd0, miso}, {31'd0, eb});
                sck = ~cpol;
                if (mid_load && i == 2) load(~tx);
                wait_clk(8);
                sck = cpol;
                wait_clk(8);
            end else begin
                sck = ~cpol;
                mosi = mb;
                if (mid_load && i == 2) load(~tx);
                wait_clk(8);
                chk({req, " miso bit"}, {31'd0, miso}, {31'd0, eb});
                sck = cpol;
                wait_clk(8);
            end
        end
        wait_clk(8);
        if (stop_at < 0) begin
            chk({req, " R7 one done"}, done_cnt, d0 + 1);
            chk({req, " R7 no abort"}, abort_cnt, a0);
            chk({req, " R2 rx word"}, {16'd0, rx_word}, {16'd0, mo & mask});
            chk({req, " R7 idle"}, {31'd0, busy}, 32'd0);
            ssel_n = 1'b1;
        end else begin
            ssel_n = 1'b1;
            wait_clk(8);
            chk({req, " R8 one abort"}, abort_cnt, a0 + 1);
            chk({req, " R8 no done"}, done_cnt, d0);
            chk({req, " R8 rx kept"}, {16'd0, rx_word}, {16'd0, prev_rx});
        end
        wait_clk(16);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 abort", {31'd0, abort_s}, 32'd0);
        chk("R1 oe", {31'd0, miso_oe}, 32'd0);
        chk("R1 rx", {16'd0, rx_word}, 32'd0);

        xfer("R5 R4 mode0 msb8",    1'b0, 1'b0, 1'b0, 4'd8,  16'h00A5, 16'h003C, -1, 1'b1, 1'b0);
        xfer("R6 R3 mode1 lsb12",   1'b0, 1'b1, 1'b1, 4'd12, 16'h0B6D, 16'h0961, -1, 1'b1, 1'b0);
        xfer("R2 R4 mode2 msb16",   1'b1, 1'b0, 1'b0, 4'd0,  16'hC3F1, 16'h8E27, -1, 1'b1, 1'b0);
        xfer("R10 R3 mode3 lsb15",  1'b1, 1'b1, 1'b1, 4'd15, 16'h5A3C, 16'h2F0D, -1, 1'b1, 1'b1);
        xfer("R10 mode0 msb9",      1'b0, 1'b0, 1'b0, 4'd9,  16'h0155, 16'h00F3, -1, 1'b1, 1'b1);
        xfer("R2 code3 as 8",       1'b0, 1'b0, 1'b1, 4'd3,  16'h0096, 16'h00C9, -1, 1'b1, 1'b0);
        xfer("R8 abort mode1",      1'b0, 1'b1, 1'b0, 4'd10, 16'h03FF, 16'h0155,  5, 1'b1, 1'b0);
        xfer("R8 tx dropped",       1'b0, 1'b0, 1'b0, 4'd8,  16'h0000, 16'h0081, -1, 1'b0, 1'b0);
        xfer("R8 abort mode0",      1'b0, 1'b0, 1'b1, 4'd0,  16'hFFFF, 16'h1234,  3, 1'b1, 1'b0);
        xfer("R8 tx dropped cpha1", 1'b1, 1'b1, 1'b1, 4'd8,  16'h0000, 16'h005A, -1, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule